// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block sequences a multicycle 32-bit load/store processor built around one shared memory for instructions and data. Every instruction passes through a common fetch step, which loads the instruction register and advances the program counter by four, and a common decode step. During decode the ALU also forms a speculative branch target from PC+4 and the shifted immediate. The opcode then steers the controller into a short path of its own. That path ends by returning to fetch. A jump path adds a third program-counter source.

The controller drives the datapath multiplexer selects and the write enables. It also produces the program-counter enable, which combines the unconditional PC write with a branch qualified by the ALU zero flag. A small ALU decoder turns the internal ALU operation class, together with the funct field, into a 3-bit ALU control code. The state register can be built binary or one-hot. Both builds behave the same at the ports.

Top module: `mc_seq_ctrl`

## Requirements
- R1: While reset (`rst`, synchronous, active high) is held, and in the first cycle after it, the controller is in fetch. Fetch drives iord=0, alu_a_sel=0, alu_b_sel=01 and pc_sel=00, asserts ir_we, pc_we and pc_en, and gives alu_ctl=010 (add).
- R2: Decode follows fetch on every instruction. It drives alu_a_sel=0, alu_b_sel=11 and alu_ctl=010, and every enable is low.
- R3: A load (opcode 100011) runs 5 cycles. After decode it passes through an address step (alu_a_sel=1, alu_b_sel=10, alu_ctl=010), then a read step (iord=1), then a write-back step (dst_sel=0, wb_sel=1, rf_we=1).
- R4: A store (opcode 101011) runs 4 cycles. After decode it takes the same address step as a load, then a write step that drives iord=1 and asserts mem_we.
- R5: A register-register instruction (opcode 000000) runs 4 cycles. After decode it takes an execute step (alu_a_sel=1, alu_b_sel=00, alu_ctl from funct), then a write-back step (dst_sel=1, wb_sel=0, rf_we=1).
- R6: A branch-if-equal (opcode 000100) runs 3 cycles. Its last step drives alu_a_sel=1, alu_b_sel=00, pc_sel=01 and alu_ctl=110, asserts br_en, and drives pc_en equal to `zero`.
- R7: An add-immediate (opcode 001000) runs 4 cycles. After decode it takes an execute step (alu_a_sel=1, alu_b_sel=10, alu_ctl=010), then a write-back step (dst_sel=0, wb_sel=0, rf_we=1).
- R8: A jump (opcode 000010) runs 3 cycles. Its last step drives pc_sel=10 and asserts pc_we and pc_en.
- R9: Any other opcode returns to fetch straight after decode, so it takes 2 cycles and asserts no write enable.
- R10: In the register-register execute step, alu_ctl follows funct: 100000 gives 010, 100010 gives 110, 100100 gives 000, 100101 gives 001, 101010 gives 111, and any other funct gives 010.
- R11: pc_en is high exactly when pc_we is high, or when br_en and `zero` are both high. `zero` has no effect on any output outside the branch step.
- R12: In each state, every enable and select that the state does not name is 0.
- R13: Reset raised in the middle of an instruction puts the controller back in fetch on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OP_W | Opcode field of the held instruction |
| funct | input | FN_W | Function field of the held instruction |
| zero | input | 1 | ALU result-is-zero flag |
| iord | output | 1 | Memory address select: 0 = PC, 1 = ALU result register |
| alu_a_sel | output | 1 | ALU A source: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B source: 00 reg B, 01 constant 4, 10 immediate, 11 shifted immediate |
| pc_sel | output | 2 | Next-PC source: 00 ALU, 01 ALU result register, 10 jump target |
| dst_sel | output | 1 | Destination register select: 0 = rt, 1 = rd |
| wb_sel | output | 1 | Write-back data select: 0 = ALU result, 1 = memory data |
| ir_we | output | 1 | Instruction register write |
| pc_we | output | 1 | Unconditional PC write |
| br_en | output | 1 | Conditional branch enable |
| rf_we | output | 1 | Register file write |
| mem_we | output | 1 | Memory write |
| pc_en | output | 1 | Qualified PC enable |
| alu_ctl | output | CTL_W | ALU operation code |

## Verification
The bench builds two copies side by side, one with the default binary state register (ONE_HOT=0) and one with ONE_HOT=1. Both copies use the default field widths. Every cycle's outputs of both copies are compared against the same expected values. The two encodings differ only in their state storage and decode, so one stimulus covers the paths of both. The zero flag is driven high during non-branch instructions, which shows that it reaches nothing outside the branch step.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;

   localparam int NUM_ST = 12;
   localparam int ST_W   = $clog2(NUM_ST);

   typedef enum logic [ST_W-1:0] {
      ST_FETCH  = 4'd0,
      ST_DECODE = 4'd1,
      ST_MADDR  = 4'd2,
      ST_MRD    = 4'd3,
      ST_MWB    = 4'd4,
      ST_MWR    = 4'd5,
      ST_EXE    = 4'd6,
      ST_AWB    = 4'd7,
      ST_BEQ    = 4'd8,
      ST_IEXE   = 4'd9,
      ST_IWB    = 4'd10,
      ST_JMP    = 4'd11
   } st_e;

   typedef enum logic [1:0] {
      AOP_ADD = 2'b00,
      AOP_SUB = 2'b01,
      AOP_FN  = 2'b10,
      AOP_RSV = 2'b11
   } aop_e;

   localparam logic [5:0] OPC_RTYPE = 6'b000000;
   localparam logic [5:0] OPC_LOAD  = 6'b100011;
   localparam logic [5:0] OPC_STORE = 6'b101011;
   localparam logic [5:0] OPC_BEQ   = 6'b000100;
   localparam logic [5:0] OPC_JUMP  = 6'b000010;
   localparam logic [5:0] OPC_ADDI  = 6'b001000;

   localparam logic [5:0] FN_ADD = 6'b100000;
   localparam logic [5:0] FN_SUB = 6'b100010;
   localparam logic [5:0] FN_AND = 6'b100100;
   localparam logic [5:0] FN_OR  = 6'b100101;
   localparam logic [5:0] FN_SLT = 6'b101010;

   localparam logic [2:0] CTL_ADD = 3'b010;
   localparam logic [2:0] CTL_SUB = 3'b110;
   localparam logic [2:0] CTL_AND = 3'b000;
   localparam logic [2:0] CTL_OR  = 3'b001;
   localparam logic [2:0] CTL_SLT = 3'b111;

   typedef struct packed {
      logic       iord;
      logic       a_sel;
      logic [1:0] b_sel;
      logic [1:0] p_sel;
      logic       dst;
      logic       wb;
      logic       ir_we;
      logic       pc_we;
      logic       br;
      logic       rf_we;
      logic       mem_we;
   } ctl_t;

endpackage

// File: rtl/mc_seq_state.sv
module mc_seq_state
   import mc_seq_pkg::*;
#(
   parameter int OP_W    = 6,
   parameter bit ONE_HOT = 1'b0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [OP_W-1:0] opcode,
   output st_e             state
);

   st_e nxt;

   // next-state selection
   always_comb begin
      nxt = ST_FETCH;
      unique case (state)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: begin
            if (opcode == OP_W'(OPC_LOAD) || opcode == OP_W'(OPC_STORE))
               nxt = ST_MADDR;
            else if (opcode == OP_W'(OPC_RTYPE))
               nxt = ST_EXE;
            else if (opcode == OP_W'(OPC_BEQ))
               nxt = ST_BEQ;
            else if (opcode == OP_W'(OPC_ADDI))
               nxt = ST_IEXE;
            else if (opcode == OP_W'(OPC_JUMP))
               nxt = ST_JMP;
            else
               nxt = ST_FETCH;
         end
         ST_MADDR: begin
            if (opcode == OP_W'(OPC_LOAD))
               nxt = ST_MRD;
            else if (opcode == OP_W'(OPC_STORE))
               nxt = ST_MWR;
            else
               nxt = ST_FETCH;
         end
         ST_MRD:   nxt = ST_MWB;
         ST_EXE:   nxt = ST_AWB;
         ST_IEXE:  nxt = ST_IWB;
         default:  nxt = ST_FETCH;
      endcase
   end

   generate
      if (ONE_HOT) begin : g_onehot
         logic [NUM_ST-1:0] oh_q;
         logic [NUM_ST-1:0] oh_d;

         always_comb begin
            oh_d      = '0;
            oh_d[nxt] = 1'b1;
         end

         always_ff @(posedge clk) begin
            if (rst) oh_q <= NUM_ST'(1);
            else     oh_q <= oh_d;
         end

         always_comb begin
            state = ST_FETCH;
            for (int i = 0; i < NUM_ST; i++) begin
               if (oh_q[i]) state = st_e'(ST_W'(i));
            end
         end
      end else begin : g_binary
         st_e st_q;

         always_ff @(posedge clk) begin
            if (rst) st_q <= ST_FETCH;
            else     st_q <= nxt;
         end

         assign state = st_q;
      end
   endgenerate

endmodule

// File: rtl/mc_seq_outdec.sv
module mc_seq_outdec
   import mc_seq_pkg::*;
(
   input  st_e  state,
   output ctl_t ctl,
   output aop_e aop
);

   always_comb begin
      ctl = '0;
      aop = AOP_ADD;
      unique case (state)
         ST_FETCH: begin
            ctl.b_sel = 2'b01;
            ctl.ir_we = 1'b1;
            ctl.pc_we = 1'b1;
         end
         ST_DECODE: begin
            ctl.b_sel = 2'b11;
         end
         ST_MADDR, ST_IEXE: begin
            ctl.a_sel = 1'b1;
            ctl.b_sel = 2'b10;
         end
         ST_MRD: begin
            ctl.iord = 1'b1;
         end
         ST_MWB: begin
            ctl.wb    = 1'b1;
            ctl.rf_we = 1'b1;
         end
         ST_MWR: begin
            ctl.iord   = 1'b1;
            ctl.mem_we = 1'b1;
         end
         ST_EXE: begin
            ctl.a_sel = 1'b1;
            aop       = AOP_FN;
         end
         ST_AWB: begin
            ctl.dst   = 1'b1;
            ctl.rf_we = 1'b1;
         end
         ST_BEQ: begin
            ctl.a_sel = 1'b1;
            ctl.p_sel = 2'b01;
            ctl.br    = 1'b1;
            aop       = AOP_SUB;
         end
         ST_IWB: begin
            ctl.rf_we = 1'b1;
         end
         ST_JMP: begin
            ctl.p_sel = 2'b10;
            ctl.pc_we = 1'b1;
         end
         default: ctl = '0;
      endcase
   end

endmodule

// File: rtl/mc_seq_aludec.sv
module mc_seq_aludec
   import mc_seq_pkg::*;
#(
   parameter int FN_W  = 6,
   parameter int CTL_W = 3
) (
   input  aop_e             aop,
   input  logic [FN_W-1:0]  funct,
   output logic [CTL_W-1:0] alu_ctl
);

   always_comb begin
      unique case (aop)
         AOP_SUB: alu_ctl = CTL_W'(CTL_SUB);
         AOP_FN: begin
            if      (funct == FN_W'(FN_ADD)) alu_ctl = CTL_W'(CTL_ADD);
            else if (funct == FN_W'(FN_SUB)) alu_ctl = CTL_W'(CTL_SUB);
            else if (funct == FN_W'(FN_AND)) alu_ctl = CTL_W'(CTL_AND);
            else if (funct == FN_W'(FN_OR))  alu_ctl = CTL_W'(CTL_OR);
            else if (funct == FN_W'(FN_SLT)) alu_ctl = CTL_W'(CTL_SLT);
            else                             alu_ctl = CTL_W'(CTL_ADD);
         end
         default: alu_ctl = CTL_W'(CTL_ADD);
      endcase
   end

endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
   import mc_seq_pkg::*;
#(
   parameter int OP_W    = 6,
   parameter int FN_W    = 6,
   parameter int CTL_W   = 3,
   parameter bit ONE_HOT = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OP_W-1:0]  opcode,
   input  logic [FN_W-1:0]  funct,
   input  logic             zero,
   output logic             iord,
   output logic             alu_a_sel,
   output logic [1:0]       alu_b_sel,
   output logic [1:0]       pc_sel,
   output logic             dst_sel,
   output logic             wb_sel,
   output logic             ir_we,
   output logic             pc_we,
   output logic             br_en,
   output logic             rf_we,
   output logic             mem_we,
   output logic             pc_en,
   output logic [CTL_W-1:0] alu_ctl
);

   generate
      if (OP_W != 6) begin : g_bad_op
         $error("mc_seq_ctrl: OP_W must be 6");
      end
      if (FN_W != 6) begin : g_bad_fn
         $error("mc_seq_ctrl: FN_W must be 6");
      end
      if (CTL_W != 3) begin : g_bad_ctl
         $error("mc_seq_ctrl: CTL_W must be 3");
      end
   endgenerate

   st_e  state;
   ctl_t ctl;
   aop_e aop;

   mc_seq_state #(
      .OP_W    (OP_W),
      .ONE_HOT (ONE_HOT)
   ) u_state (
      .clk    (clk),
      .rst    (rst),
      .opcode (opcode),
      .state  (state)
   );

   mc_seq_outdec u_outdec (
      .state (state),
      .ctl   (ctl),
      .aop   (aop)
   );

   mc_seq_aludec #(
      .FN_W  (FN_W),
      .CTL_W (CTL_W)
   ) u_aludec (
      .aop     (aop),
      .funct   (funct),
      .alu_ctl (alu_ctl)
   );

   assign iord      = ctl.iord;
   assign alu_a_sel = ctl.a_sel;
   assign alu_b_sel = ctl.b_sel;
   assign pc_sel    = ctl.p_sel;
   assign dst_sel   = ctl.dst;
   assign wb_sel    = ctl.wb;
   assign ir_we     = ctl.ir_we;
   assign pc_we     = ctl.pc_we;
   assign br_en     = ctl.br;
   assign rf_we     = ctl.rf_we;
   assign mem_we    = ctl.mem_we;
   assign pc_en     = ctl.pc_we | (ctl.br & zero);

endmodule

// File: rtl/mc_seq_chk.sv
module mc_seq_chk (
   input logic       clk,
   input logic       rst,
   input logic       zero,
   input logic       iord,
   input logic [1:0] alu_b_sel,
   input logic [1:0] pc_sel,
   input logic       ir_we,
   input logic       pc_we,
   input logic       br_en,
   input logic       rf_we,
   input logic       mem_we,
   input logic       pc_en
);

   AST_FETCH_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> ir_we); // R1

   AST_DECODE_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (rst)
      ir_we |=> (alu_b_sel == 2'b11 && !ir_we)); // R2

   AST_STORE_USES_ALUOUT: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> iord); // R4

   AST_RFWE_RETURNS: assert property (@(posedge clk) disable iff (rst)
      rf_we |=> ir_we); // R5

   AST_BRANCH_RETURNS: assert property (@(posedge clk) disable iff (rst)
      br_en |=> ir_we); // R6

   AST_JUMP_RETURNS: assert property (@(posedge clk) disable iff (rst)
      (pc_sel == 2'b10) |=> ir_we); // R8

   AST_PCEN_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (br_en && zero) |-> pc_en); // R11

   AST_PCEN_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!pc_we && !br_en) |-> !pc_en); // R11

   AST_WRITES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ir_we, rf_we, mem_we})); // R12

endmodule

bind mc_seq_ctrl mc_seq_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .zero      (zero),
   .iord      (iord),
   .alu_b_sel (alu_b_sel),
   .pc_sel    (pc_sel),
   .ir_we     (ir_we),
   .pc_we     (pc_we),
   .br_en     (br_en),
   .rf_we     (rf_we),
   .mem_we    (mem_we),
   .pc_en     (pc_en)
);

// File: tb/test_mc_seq_ctrl.sv
module test_mc_seq_ctrl;

   localparam int CLK_P  = 10;
   localparam int N_VEC  = 16;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] opcode = '0;
   logic [5:0] funct  = '0;
   logic       zero   = 1'b0;

   logic       b_iord, b_asel, b_dst, b_wb, b_irwe, b_pcwe, b_br, b_rfwe, b_mwe, b_pcen;
   logic [1:0] b_bsel, b_psel;
   logic [2:0] b_ctl;
   logic       o_iord, o_asel, o_dst, o_wb, o_irwe, o_pcwe, o_br, o_rfwe, o_mwe, o_pcen;
   logic [1:0] o_bsel, o_psel;
   logic [2:0] o_ctl;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_P/2) clk = ~clk;

   mc_seq_ctrl #(.ONE_HOT(1'b0)) i_mc_seq_ctrl (
      .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .zero(zero),
      .iord(b_iord), .alu_a_sel(b_asel), .alu_b_sel(b_bsel), .pc_sel(b_psel),
      .dst_sel(b_dst), .wb_sel(b_wb), .ir_we(b_irwe), .pc_we(b_pcwe),
      .br_en(b_br), .rf_we(b_rfwe), .mem_we(b_mwe), .pc_en(b_pcen), .alu_ctl(b_ctl)
   );

   mc_seq_ctrl #(.ONE_HOT(1'b1)) i_mc_seq_ctrl_oh (
      .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .zero(zero),
      .iord(o_iord), .alu_a_sel(o_asel), .alu_b_sel(o_bsel), .pc_sel(o_psel),
      .dst_sel(o_dst), .wb_sel(o_wb), .ir_we(o_irwe), .pc_we(o_pcwe),
      .br_en(o_br), .rf_we(o_rfwe), .mem_we(o_mwe), .pc_en(o_pcen), .alu_ctl(o_ctl)
   );

   // {iord, asel, bsel[1:0], psel[1:0], dst, wb, irwe, pcwe, br, rfwe, mwe, pcen, ctl[2:0]}
   wire [16:0] act_b = {b_iord, b_asel, b_bsel, b_psel, b_dst, b_wb, b_irwe, b_pcwe,
                        b_br, b_rfwe, b_mwe, b_pcen, b_ctl};
   wire [16:0] act_o = {o_iord, o_asel, o_bsel, o_psel, o_dst, o_wb, o_irwe, o_pcwe,
                        o_br, o_rfwe, o_mwe, o_pcen, o_ctl};

   // stimulus table: {opcode, funct, zero}
   localparam logic [12:0] VEC [N_VEC] = '{
      {6'b100011, 6'b000000, 1'b0},   // load
      {6'b100011, 6'b111111, 1'b1},   // load, zero high
      {6'b101011, 6'b000000, 1'b1},   // store
      {6'b000000, 6'b100000, 1'b0},   // add
      {6'b000000, 6'b100010, 1'b1},   // sub
      {6'b000000, 6'b100100, 1'b0},   // and
      {6'b000000, 6'b100101, 1'b1},   // or
      {6'b000000, 6'b101010, 1'b0},   // slt
      {6'b000000, 6'b000000, 1'b1},   // unlisted funct
      {6'b000100, 6'b000000, 1'b1},   // beq taken
      {6'b000100, 6'b000000, 1'b0},   // beq not taken
      {6'b001000, 6'b100010, 1'b1},   // addi
      {6'b000010, 6'b000000, 1'b1},   // jump
      {6'b000010, 6'b000000, 1'b0},   // jump, zero low
      {6'b111111, 6'b000000, 1'b1},   // unknown
      {6'b001100, 6'b100000, 1'b0}    // unknown
   };

   function automatic int path_len(input logic [5:0] op);
      case (op)
         6'b100011: return 5;
         6'b101011, 6'b000000, 6'b001000: return 4;
         6'b000100, 6'b000010: return 3;
         default: return 2;
      endcase
   endfunction

   function automatic logic [2:0] fn_ctl(input logic [5:0] fn);
      case (fn)
         6'b100000: return 3'b010;
         6'b100010: return 3'b110;
         6'b100100: return 3'b000;
         6'b100101: return 3'b001;
         6'b101010: return 3'b111;
         default:   return 3'b010;
      endcase
   endfunction

   function automatic string step_tag(input logic [5:0] op, input int step);
      if (step == 0) return "R1";
      if (step == 1) return "R2";
      case (op)
         6'b100011: return "R3";
         6'b101011: return "R4";
         6'b000000: return (step == 2) ? "R10" : "R5";
         6'b000100: return "R6";
         6'b001000: return "R7";
         6'b000010: return "R8";
         default:   return "R9";
      endcase
   endfunction

   function automatic logic [16:0] exp_vec(input logic [5:0] op, input logic [5:0] fn,
                                           input logic z, input int step);
      logic       iord = 0, asel = 0, dst = 0, wb = 0, irwe = 0, pcwe = 0;
      logic       br = 0, rfwe = 0, mwe = 0, pcen = 0;
      logic [1:0] bsel = 2'b00, psel = 2'b00;
      logic [2:0] ctl = 3'b010;
      if (step == 0) begin
         bsel = 2'b01; irwe = 1; pcwe = 1; pcen = 1;
      end else if (step == 1) begin
         bsel = 2'b11;
      end else begin
         case (op)
            6'b100011, 6'b101011: begin
               if (step == 2) begin asel = 1; bsel = 2'b10; end
               else if (op == 6'b101011) begin iord = 1; mwe = 1; end
               else if (step == 3) iord = 1;
               else begin wb = 1; rfwe = 1; end
            end
            6'b000000: begin
               if (step == 2) begin asel = 1; ctl = fn_ctl(fn); end
               else begin dst = 1; rfwe = 1; end
            end
            6'b000100: begin
               asel = 1; psel = 2'b01; br = 1; pcen = z; ctl = 3'b110;
            end
            6'b001000: begin
               if (step == 2) begin asel = 1; bsel = 2'b10; end
               else rfwe = 1;
            end
            6'b000010: begin
               psel = 2'b10; pcwe = 1; pcen = 1;
            end
            default: ;
         endcase
      end
      return {iord, asel, bsel, psel, dst, wb, irwe, pcwe, br, rfwe, mwe, pcen, ctl};
   endfunction

   task automatic check_both(input logic [16:0] exp, input string tag, input string what);
      n_checks++;
      if (act_b !== exp) begin
         n_fail++;
         $display("FAIL %s %s binary: actual=%b expected=%b", tag, what, act_b, exp);
      end
      n_checks++;
      if (act_o !== exp) begin
         n_fail++;
         $display("FAIL %s %s onehot: actual=%b expected=%b", tag, what, act_o, exp);
      end
   endtask

   // runs one instruction starting at a negedge where fetch is current;
   // ends on the negedge of the next fetch
   task automatic run_instr(input logic [5:0] op, input logic [5:0] fn, input logic z);
      int n = path_len(op);
      for (int s = 0; s < n; s++) begin
         opcode = op; funct = fn; zero = z;
         #1;
         check_both(exp_vec(op, fn, z, s), step_tag(op, s), $sformatf("op=%b step=%0d", op, s));
         @(negedge clk);
      end
   endtask

   initial begin
      #(CLK_P * 20000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      // R1: reset held keeps fetch, even with decode-bound opcode
      opcode = 6'b100011; zero = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check_both(exp_vec(6'b0, 6'b0, 1'b0, 0), "R1", "during reset");
      @(negedge clk);
      #1;
      check_both(exp_vec(6'b0, 6'b0, 1'b0, 0), "R1", "reset still held");
      rst = 1'b0;

      // table walk
      for (int v = 0; v < N_VEC; v++) begin
         run_instr(VEC[v][12:7], VEC[v][6:1], VEC[v][0]);
      end

      // R11: zero toggled inside a non-branch path leaves outputs alone
      opcode = 6'b001000; funct = 6'b0; zero = 1'b0;
      #1;
      check_both(exp_vec(6'b001000, 6'b0, 1'b0, 0), "R11", "fetch zero low");
      @(negedge clk);
      zero = 1'b1;
      #1;
      check_both(exp_vec(6'b001000, 6'b0, 1'b0, 1), "R11", "decode zero high");
      @(negedge clk);
      zero = 1'b0;
      #1;
      check_both(exp_vec(6'b001000, 6'b0, 1'b0, 2), "R11", "addi exec zero low");
      zero = 1'b1;
      #1;
      check_both(exp_vec(6'b001000, 6'b0, 1'b0, 2), "R11", "addi exec zero high");
      @(negedge clk);
      #1;
      check_both(exp_vec(6'b001000, 6'b0, 1'b1, 3), "R12", "addi writeback");
      @(negedge clk);

      // R13: reset raised during the read step of a load
      opcode = 6'b100011; funct = 6'b0; zero = 1'b0;
      #1;
      check_both(exp_vec(6'b100011, 6'b0, 1'b0, 0), "R13", "load fetch");
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      #1;
      check_both(exp_vec(6'b100011, 6'b0, 1'b0, 3), "R13", "load read before reset");
      rst = 1'b1;
      #1;
      check_both(exp_vec(6'b100011, 6'b0, 1'b0, 3), "R13", "reset not yet clocked");
      @(negedge clk);
      #1;
      check_both(exp_vec(6'b0, 6'b0, 1'b0, 0), "R13", "fetch after mid reset");
      rst = 1'b0;

      // R6: branch right after reset, taken then beq not taken
      run_instr(6'b000100, 6'b0, 1'b1);
      run_instr(6'b000100, 6'b0, 1'b0);
      // R9: unknown then a store, to see clean return
      run_instr(6'b010101, 6'b0, 1'b1);
      run_instr(6'b101011, 6'b0, 1'b0);
      #1;
      check_both(exp_vec(6'b0, 6'b0, 1'b0, 0), "R4", "fetch after store");

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule